// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master end of a two-wire serial management link to external Ethernet PHY devices. It reads or writes one 16-bit register per transaction. A transaction is addressed by a 5-bit PHY number and a 5-bit register number, so up to 32 devices with 32 registers each can be reached. The host side has two indirect registers. The data register is written with the value to send, and it is read back as `rd_data`. A control write carries the direction, both address fields and a start flag.

Once started, the block divides the system clock into the management clock `mdc`, which idles low. It then shifts out one 64-bit frame. Bits go out most significant first: 32 preamble ones, the start pattern 01, the opcode, the PHY number, the register number, a 2-bit turnaround and 16 data bits. Outgoing bits change only on the falling edge of `mdc`, so each bit is stable at the rising edge where the PHY samples it.

For a read, the block releases the line from the turnaround onward by dropping `mdio_oe`. It samples `mdio_i` at each rising edge of the 16 data bits and loads the result into the data register. The pad itself (`mdio_o`, `mdio_oe`, `mdio_i`) sits outside this block. With the default divide of 30 and a 100 MHz system clock, `mdc` runs at about 1.67 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are 0, and `rd_data` is 0.
- R2: Every frame starts with 32 ones on the line, followed by the start pattern 0 then 1.
- R3: The 2-bit opcode after the start pattern is 1,0 for a read (`ctl_rd`=1) and 0,1 for a write.
- R4: After the opcode come `ctl_phy` and then `ctl_reg`, each 5 bits, most significant bit first.
- R5: A write drives the line for all 64 bits. The turnaround is 1 then 0, and the data field is the data register, most significant bit first.
- R6: A read keeps `mdio_oe` high for bits 0 to 45 and low for bits 46 to 63. The 16 line values sampled at the rising `mdc` edges of bits 48 to 63, most significant first, appear on `rd_data` in the cycle that `done` is high.
- R7: `mdc` is low while idle, has a period of 2*DIV_HALF system clocks during a frame, and rises exactly 64 times per frame.
- R8: `mdio_o` and `mdio_oe` never change while `mdc` is high or at its rising edge. They change only together with a falling edge of `mdc`, or at frame start and end.
- R9: A start (`ctl_we` and `ctl_start` high while idle) raises `busy` at the next clock edge. `busy` stays high for exactly 128*DIV_HALF cycles. `done` is high for one cycle, in the first cycle with `busy` low.
- R10: While `busy` is high, control writes, start requests and data register writes are ignored. The running frame, its length and the data register are unchanged.
- R11: A data register write while idle shows on `rd_data` from the next cycle. The data must be written before the start cycle to be sent.
- R12: Whenever `busy` is low, `mdio_oe` is 0, so the line is released to its pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start flag of the control write |
| ctl_rd | input | 1 | 1 = read transaction, 0 = write |
| ctl_phy | input | 5 | PHY number |
| ctl_reg | input | 5 | Register number inside the PHY |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Value for the data register |
| rd_data | output | 16 | Data register contents |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Line value from the pad |
| mdio_o | output | 1 | Value driven onto the line |
| mdio_oe | output | 1 | Drive enable for the line |

## Verification
The bench issues a start at one falling system-clock edge, so the start is taken at the next rising edge. `busy` must then be high at every later falling-edge sample for 128*DIV_HALF samples. The bench records the line and `mdio_oe` at the first falling-edge sample after each `mdc` rise, which is the value the PHY latched. Its modelled PHY changes `mdio_i` at that same sample, one full half-period before the next rising edge where the design samples. `done` and the updated `rd_data` are checked at the first sample where `busy` is low, and `done` must be low again one sample later. Data register writes are checked one sample after their strobe.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int TA_FIRST   = FRAME_BITS - DATA_W - 2;
  localparam int DATA_FIRST = FRAME_BITS - DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_cmd_t;

  // Whole frame, first bit on the wire in the top position.
  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic [DATA_W-1:0] wd);
    logic [1:0] opc;
    logic [DATA_W-1:0] fld;
    opc = c.rd ? 2'b10 : 2'b01;
    fld = c.rd ? '0 : wd;
    return {{PRE_BITS{1'b1}}, 2'b01, opc, c.phy, c.regad, 2'b10, fld};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          ph;
  logic          wrap;

  assign wrap = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mdc      = ph;
  assign rise_stb = wrap && !ph;
  assign fall_stb = wrap && ph;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_start,
  input  logic              ctl_rd,
  input  logic [ADDR_W-1:0] ctl_phy,
  input  logic [ADDR_W-1:0] ctl_reg,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              fin_rd,
  input  logic [DATA_W-1:0] rx_data,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic [DATA_W-1:0] data_q
);
  assign start = ctl_we && ctl_start && !busy;
  assign cmd   = '{rd: ctl_rd, phy: ctl_phy, regad: ctl_reg};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (fin && fin_rd) begin
      data_q <= rx_data;
    end else if (dat_we && !busy) begin
      data_q <= dat_wdata;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              fin,
  output logic              fin_rd,
  output logic [DATA_W-1:0] rx_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sr;
  logic [IDX_W-1:0]      bidx;
  logic                  is_rd;
  logic                  oe_q;
  logic                  busy_q;
  logic                  done_q;
  logic [DATA_W-1:0]     rx;

  assign fin    = busy_q && fall_stb && (bidx == LAST_IDX);
  assign fin_rd = is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      bidx   <= '0;
      is_rd  <= 1'b0;
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rx     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        sr     <= build_frame(cmd, wdata);
        bidx   <= '0;
        is_rd  <= cmd.rd;
        oe_q   <= 1'b1;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (rise_stb && is_rd && (int'(bidx) >= DATA_FIRST)) begin
          rx <= {rx[DATA_W-2:0], mdio_i};
        end
        if (fall_stb) begin
          if (bidx == LAST_IDX) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            oe_q   <= 1'b0;
            sr     <= '0;
          end else begin
            bidx <= bidx + 1'b1;
            sr   <= {sr[FRAME_BITS-2:0], 1'b0};
            oe_q <= !(is_rd && (int'(bidx) + 1 >= TA_FIRST));
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign mdio_o  = sr[FRAME_BITS-1];
  assign mdio_oe = oe_q;
  assign rx_data = rx;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_start,
  input  logic              ctl_rd,
  input  logic [ADDR_W-1:0] ctl_phy,
  input  logic [ADDR_W-1:0] ctl_reg,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic              start;
  mdio_cmd_t         cmd;
  logic              rise_stb;
  logic              fall_stb;
  logic              fin;
  logic              fin_rd;
  logic [DATA_W-1:0] rx_data;

  mdio_host_regs u_regs (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_rd(ctl_rd),
    .ctl_phy(ctl_phy), .ctl_reg(ctl_reg),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .busy(busy), .fin(fin), .fin_rd(fin_rd), .rx_data(rx_data),
    .start(start), .cmd(cmd), .data_q(rd_data)
  );

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .wdata(rd_data),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .fin(fin), .fin_rd(fin_rd), .rx_data(rx_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_HALF = 30
) (
  input logic clk,
  input logic rst,
  input logic ctl_we,
  input logic ctl_start,
  input logic ctl_rd,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  logic        rd_l;
  logic        mdc_q;
  logic [6:0]  rises;
  logic [31:0] bcyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_l  <= 1'b0;
      mdc_q <= 1'b0;
      rises <= '0;
      bcyc  <= '0;
    end else begin
      mdc_q <= mdc;
      if (ctl_we && ctl_start && !busy) begin
        rd_l  <= ctl_rd;
        rises <= '0;
        bcyc  <= '0;
      end else begin
        if (mdc && !mdc_q) rises <= rises + 1'b1;
        if (busy) bcyc <= bcyc + 1'b1;
      end
    end
  end

  a_r12_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc));
  a_r8_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctl_we && ctl_start));
  a_r10_frame_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcyc == 32'(128 * DIV_HALF)));
  a_r7_rise_count: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (rises == 7'd64));
  a_r6_read_released: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_l && rises >= 7'd46 && !mdc) |-> !mdio_oe);
  a_r5_write_driven: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_l) |-> mdio_oe);
endmodule

bind mdio_master mdio_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_rd(ctl_rd),
  .busy(busy), .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0, ctl_start = 1'b0, ctl_rd = 1'b0;
  logic [4:0] ctl_phy = '0, ctl_reg = '0;
  logic dat_we = 1'b0;
  logic [15:0] dat_wdata = '0;
  logic [15:0] rd_data;
  logic busy, done, mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_en = 1'b0, phy_val = 1'b1;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_master #(.DIV_HALF(DIV)) uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_rd(ctl_rd),
    .ctl_phy(ctl_phy), .ctl_reg(ctl_reg), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
  endfunction

  task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] d, input bit disturb);
    logic [63:0] bits = '0, oev = '0, expf, expoe;
    int rises = 0, bcyc = 0, hbad = 0, pbad = 0, lastr = 0, k;
    bit pm, seen = 0;
    logic po, poe;
    if (!rd) begin
      @(negedge clk); dat_we = 1'b1; dat_wdata = d;
      @(negedge clk); dat_we = 1'b0;
      chk("R11 data register write", rd_data == d, 64'(rd_data), 64'(d));
    end
    @(negedge clk);
    ctl_we = 1'b1; ctl_start = 1'b1; ctl_rd = rd; ctl_phy = pa; ctl_reg = ra;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    for (int cyc = 0; cyc < 2000 && !seen; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin ctl_we = 1'b0; ctl_start = 1'b0; end
      if (disturb && cyc == 40) begin
        dat_we = 1'b1; dat_wdata = ~d; ctl_we = 1'b1; ctl_start = 1'b1;
        ctl_rd = !rd; ctl_phy = ~pa; ctl_reg = ~ra;
      end
      if (disturb && cyc == 41) begin dat_we = 1'b0; ctl_we = 1'b0; ctl_start = 1'b0; end
      if (busy) bcyc++;
      if (mdc && (mdio_o !== po || mdio_oe !== poe)) hbad++;
      if (mdc && !pm) begin
        if (rises > 0 && cyc - lastr != 2*DIV) pbad++;
        lastr = cyc;
        if (rises < 64) begin bits[63-rises] = mdio_i; oev[63-rises] = mdio_oe; end
        rises++;
        k = rises;
        if (rd && k == 47) begin phy_en = 1'b1; phy_val = 1'b0; end
        else if (rd && k >= 48 && k <= 63) begin phy_en = 1'b1; phy_val = d[63-k]; end
        else phy_en = 1'b0;
      end
      pm = mdc; po = mdio_o; poe = mdio_oe;
      if (done) begin
        seen = 1;
        chk("R9 busy low with done", !busy, 64'(busy), 64'd0);
        chk("R6 R11 rd_data at done", rd_data == d, 64'(rd_data), 64'(d));
      end
    end
    phy_en = 1'b0;
    expf = exp_frame(rd, pa, ra, d);
    expoe = rd ? 64'hFFFF_FFFF_FFFC_0000 : '1;
    chk("R9 done seen", seen, 64'(seen), 64'd1);
    chk("R2 preamble and start", bits[63:30] == expf[63:30], bits, expf);
    chk("R3 opcode", bits[29:28] == expf[29:28], 64'(bits[29:28]), 64'(expf[29:28]));
    chk("R4 phy and register fields", bits[27:18] == expf[27:18], 64'(bits[27:18]), 64'(expf[27:18]));
    if (rd) begin
      chk("R6 read turnaround and data", bits[17:0] == expf[17:0], 64'(bits[17:0]), 64'(expf[17:0]));
      chk("R6 read drive enable", oev == expoe, oev, expoe);
    end else begin
      chk("R5 write turnaround and data", bits[17:0] == expf[17:0], 64'(bits[17:0]), 64'(expf[17:0]));
      chk("R5 write drive enable", oev == expoe, oev, expoe);
    end
    chk("R7 rise count", rises == 64, 64'(rises), 64'd64);
    chk("R7 mdc period", pbad == 0, 64'(pbad), 64'd0);
    chk("R8 outputs stable while mdc high", hbad == 0, 64'(hbad), 64'd0);
    chk("R9 busy length", bcyc == 128*DIV, 64'(bcyc), 64'(128*DIV));
    if (disturb)
      chk("R10 ignored while busy", bits == expf && bcyc == 128*DIV && rd_data == d,
          bits, expf);
    @(negedge clk);
    chk("R9 done one cycle", !done, 64'(done), 64'd0);
    chk("R12 released when idle", !mdio_oe && !mdc, {62'd0, mdio_oe, mdc}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk("R1 reset state", !busy && !done && !mdc && !mdio_oe && rd_data == 16'd0,
        {44'd0, rd_data, busy, done, mdc, mdio_oe}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", !busy && !mdc && !mdio_oe, {61'd0, busy, mdc, mdio_oe}, 64'd0);
    // directed corners
    run_txn(1'b0, 5'd0, 5'd0, 16'h0000, 1'b0);
    run_txn(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'd0, 5'd31, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd31, 5'd0, 16'hFFFF, 1'b0);
    run_txn(1'b0, 5'h15, 5'h0A, 16'hA5A5, 1'b1);
    run_txn(1'b1, 5'h0A, 5'h15, 16'h5A3C, 1'b1);
    // random traffic
    for (int i = 0; i < 20; i++) begin
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 1'($urandom % 4 == 0));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule